// File: doc/BRIEF.md
# Flash Bank Mirror Address Translator

This block sits on the request path between a bus master and a 1 MB flash array that is organised as a lower half (0x00000–0x7FFFF) and an upper half (0x80000–0xFFFFF). Once software has staged a new image in the inactive half, it asks for a mirror swap. After the swap, read and instruction-fetch requests aimed at either half are served from the other half. Program and erase requests always carry the physical address. For example, after a swap a read of 0x03FEC is served from 0x83FEC, and erasing that same word also needs 0x83FEC.

A swap request is a single-cycle write strobe. If the flash banks are idle, the mirror state flips at the next clock edge, and the prefetch buffers get a one-cycle invalidate pulse in the cycle that decides the flip. If the banks are busy, the request waits as pending until the first idle cycle. While a swap is requested or pending, read and fetch requests are held back, so the first one accepted afterwards already sees the new mapping. The mapping stays in force until the next swap. Addresses above the 1 MB window pass through untouched.

The request path is a valid/ready stream with no storage: `fl_valid` follows `req_valid` and `req_ready` follows `fl_ready`. The only exception is that read and fetch requests are stalled (valid and ready both low) during a swap. A master must hold its request stable until it sees `req_valid && req_ready` at a clock edge.

Top module: `fmx_translator`

## Requirements
- R1: After reset the mirror state is 0, no swap is pending and the prefetch invalidate output is low.
- R2: With the mirror state 0, read (kind 0) and fetch (kind 1) requests leave with their address unchanged.
- R3: With the mirror state 1, read and fetch addresses inside 0x00000–0xFFFFF leave with bit 19 inverted: 0x03FEC becomes 0x83FEC and 0x83FEC becomes 0x03FEC.
- R4: Program (kind 2) and erase (kind 3) requests always leave with their physical address, whatever the mirror state.
- R5: Addresses at or above 0x100000 leave unchanged for every kind and every mirror state.
- R6: A swap strobe in a cycle where `banks_idle` is high flips the mirror state at that clock edge and raises `pf_inval` for exactly that one cycle.
- R7: A swap strobe while `banks_idle` is low sets `swap_pending` and leaves the mirror state and `pf_inval` unchanged. The flip and the one-cycle `pf_inval` happen in the first cycle in which `banks_idle` is high, and `swap_pending` then clears.
- R8: While a swap strobe is present or a swap is pending, read and fetch requests see `req_ready` low and produce no `fl_valid`. Program and erase requests still pass.
- R9: The stream carries no storage. When not stalled, `fl_valid` equals `req_valid`, `req_ready` equals `fl_ready`, and a low `fl_ready` holds the request with `req_ready` low.
- R10: The mapping persists between swaps, and a second swap returns to the unswapped mapping.
- R11: Several swap strobes received while one swap is pending produce a single flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_wr | input | 1 | One-cycle strobe: write 1 to the mirror-enable control |
| banks_idle | input | 1 | High when every flash bank is idle |
| mirror_state | output | 1 | Status: 1 when the halves are swapped |
| swap_pending | output | 1 | A swap is waiting for the banks to go idle |
| pf_inval | output | 1 | One-cycle prefetch buffer invalidate |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_kind | input | 2 | 0 read, 1 fetch, 2 program, 3 erase |
| req_addr | input | ADDR_W | Request byte address |
| fl_valid | output | 1 | Request valid towards the flash |
| fl_ready | input | 1 | Flash can take the request |
| fl_kind | output | 2 | Access kind towards the flash |
| fl_addr | output | ADDR_W | Translated address towards the flash |

## Verification
If the mirror state is wrong, the very next read or fetch inside the window arrives at the flash with bit 19 of the wrong polarity. The scoreboard flags this at that single handshake. If the pending state is wrong, the effect shows within one cycle as a read that slips through during a busy phase, a flip while the banks are busy, or a missing or doubled `pf_inval` pulse. The bench therefore compares every accepted request against a mapping it models on its own, and it checks the status pins in the cycle of each swap decision and the cycle after.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_FETCH = 2'd1,
    ACC_PROG  = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_e;

  // Only read-side traffic follows the mirror mapping.
  function automatic logic follows_mirror(acc_kind_e k);
    return (k == ACC_READ) || (k == ACC_FETCH);
  endfunction
endpackage

// File: rtl/fmx_swap_ctrl.sv
module fmx_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic swap_wr,
  input  logic banks_idle,
  output logic mirror_q,
  output logic pending_q,
  output logic swap_busy,
  output logic inval_pulse
);
  logic fire;

  assign swap_busy   = swap_wr | pending_q;
  assign fire        = swap_busy & banks_idle;
  assign inval_pulse = fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mirror_q  <= 1'b0;
      pending_q <= 1'b0;
    end else if (fire) begin
      mirror_q  <= ~mirror_q;
      pending_q <= 1'b0;
    end else if (swap_wr) begin
      pending_q <= 1'b1;
    end
  end

  // R6: the invalidate pulse marks the cycle whose edge flips the state
  p_inval_flips_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |=> (mirror_q != $past(mirror_q)));

  // R7: without a pulse the mirror state holds
  p_no_flip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !inval_pulse |=> $stable(mirror_q));

  // R7: a pending swap survives a busy cycle
  p_pending_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && !banks_idle) |=> pending_q);

  // R7: a pending swap resolves in the first idle cycle
  p_pending_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q && banks_idle) |=> !pending_q);

  // R6: the pulse is never raised while banks are busy
  p_inval_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inval_pulse |-> banks_idle);
endmodule

// File: rtl/fmx_remap.sv
module fmx_remap #(
  parameter int ADDR_W = 24,
  parameter int SPAN_W = 20
) (
  input  logic              mirror,
  input  fmx_pkg::acc_kind_e kind,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HALF_BIT = SPAN_W - 1;

  logic in_window;

  generate
    if (ADDR_W > SPAN_W) begin : g_window
      assign in_window = (addr_i[ADDR_W-1:SPAN_W] == '0);
    end else begin : g_full
      assign in_window = 1'b1;
    end
  endgenerate

  logic flip;
  assign flip = mirror & in_window & fmx_pkg::follows_mirror(kind);

  always_comb begin
    addr_o = addr_i;
    addr_o[HALF_BIT] = addr_i[HALF_BIT] ^ flip;
  end
endmodule

// File: rtl/fmx_translator.sv
module fmx_translator #(
  parameter int ADDR_W = 24,
  parameter int SPAN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_wr,
  input  logic              banks_idle,
  output logic              mirror_state,
  output logic              swap_pending,
  output logic              pf_inval,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fl_valid,
  input  logic              fl_ready,
  output logic [1:0]        fl_kind,
  output logic [ADDR_W-1:0] fl_addr
);
  import fmx_pkg::*;

  acc_kind_e kind;
  logic      swap_busy;
  logic      stall;

  assign kind = acc_kind_e'(req_kind);

  fmx_swap_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .swap_wr    (swap_wr),
    .banks_idle (banks_idle),
    .mirror_q   (mirror_state),
    .pending_q  (swap_pending),
    .swap_busy  (swap_busy),
    .inval_pulse(pf_inval)
  );

  fmx_remap #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_remap (
    .mirror (mirror_state),
    .kind   (kind),
    .addr_i (req_addr),
    .addr_o (fl_addr)
  );

  assign stall     = swap_busy & follows_mirror(kind);
  assign fl_valid  = req_valid & ~stall;
  assign req_ready = fl_ready & ~stall;
  assign fl_kind   = req_kind;

  // R8: no read or fetch leaves while a swap waits
  p_stall_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pending |-> !(fl_valid && follows_mirror(acc_kind_e'(fl_kind))));

  // R4: program and erase keep the physical address
  p_phys_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_valid && !follows_mirror(acc_kind_e'(fl_kind))) |-> (fl_addr == req_addr));

  // R9: back-pressure from the flash reaches the master
  p_backpressure_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_ready |-> !req_ready);
endmodule

// File: tb/fmx_translator_bench.sv
module fmx_translator_bench;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          swap_wr = 1'b0;
  logic          banks_idle = 1'b1;
  logic          mirror_state, swap_pending, pf_inval;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic          fl_valid;
  logic          fl_ready = 1'b1;
  logic [1:0]    fl_kind;
  logic [AW-1:0] fl_addr;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit model_mirror = 1'b0;
  logic [AW+1:0] sb_q[$];

  always #10 clk = ~clk;

  fmx_translator #(.ADDR_W(AW)) u_fmx_translator (
    .clk(clk), .rst_n(rst_n), .swap_wr(swap_wr), .banks_idle(banks_idle),
    .mirror_state(mirror_state), .swap_pending(swap_pending), .pf_inval(pf_inval),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .fl_valid(fl_valid), .fl_ready(fl_ready),
    .fl_kind(fl_kind), .fl_addr(fl_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model_addr(input logic [1:0] k, input logic [AW-1:0] a);
    if (k < 2 && model_mirror && a < 24'h100000) return a ^ 24'h080000;
    return a;
  endfunction

  // Monitor: compares every handshake at the flash side with the scoreboard
  always @(negedge clk) begin
    #5;
    if (fl_valid && fl_ready) begin
      if (sb_q.size() == 0) begin
        chk("R8 unexpected request", {6'd0, fl_kind, fl_addr}, 32'hFFFFFFFF);
      end else begin
        logic [AW+1:0] e;
        e = sb_q.pop_front();
        chk("R2/R3/R4/R5 translated request", {6'd0, fl_kind, fl_addr}, {6'd0, e});
      end
    end
  end

  // Driver: pushes the expected item and holds the request until accepted
  task automatic send(input logic [1:0] k, input logic [AW-1:0] a);
    @(negedge clk);
    #1;
    req_kind = k; req_addr = a; req_valid = 1'b1;
    sb_q.push_back({k, model_addr(k, a)});
    forever begin
      #5;
      if (req_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic swap_idle();
    @(negedge clk);
    #1;
    swap_wr = 1'b1; banks_idle = 1'b1;
    #5;
    chk("R6 pf_inval in decision cycle", pf_inval, 1);
    @(negedge clk);
    #1;
    swap_wr = 1'b0;
    model_mirror = ~model_mirror;
    #5;
    chk("R6 mirror flipped", mirror_state, model_mirror);
    chk("R6 pf_inval one cycle", pf_inval, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 mirror_state reset", mirror_state, 0);
    chk("R1 swap_pending reset", swap_pending, 0);
    chk("R1 pf_inval reset", pf_inval, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: unswapped reads and fetches
    send(2'd0, 24'h003FEC);
    send(2'd1, 24'h083FE8);
    send(2'd2, 24'h004010);

    // R6: swap while idle
    swap_idle();
    // R3: both directions flipped
    send(2'd0, 24'h003FEC);
    send(2'd1, 24'h083FEC);
    send(2'd1, 24'h07FFFC);
    // R4: program and erase stay physical
    send(2'd2, 24'h083FEC);
    send(2'd3, 24'h003FE8);
    // R5: outside window
    send(2'd0, 24'h103FEC);
    send(2'd1, 24'hFFFFFC);

    // R9: back-pressure
    @(negedge clk);
    #1;
    fl_ready = 1'b0; req_kind = 2'd0; req_addr = 24'h000010; req_valid = 1'b1;
    #5;
    chk("R9 req_ready low under back-pressure", req_ready, 0);
    chk("R9 fl_valid follows req_valid", fl_valid, 1);
    @(negedge clk);
    #1;
    req_valid = 1'b0; fl_ready = 1'b1;

    // R7 / R11: swap requests while busy
    @(negedge clk);
    #1;
    banks_idle = 1'b0; swap_wr = 1'b1;
    #5;
    chk("R7 no pulse while busy", pf_inval, 0);
    @(negedge clk);
    #1;
    swap_wr = 1'b0;
    #5;
    chk("R7 pending set", swap_pending, 1);
    chk("R7 mirror held while busy", mirror_state, model_mirror);
    @(negedge clk);
    #1;
    swap_wr = 1'b1;
    @(negedge clk);
    #1;
    swap_wr = 1'b0;
    // R8: read stalled, program passes
    req_kind = 2'd1; req_addr = 24'h000020; req_valid = 1'b1;
    #5;
    chk("R8 fetch stalled req_ready", req_ready, 0);
    chk("R8 fetch stalled fl_valid", fl_valid, 0);
    @(negedge clk);
    #1;
    req_valid = 1'b0;
    send(2'd2, 24'h000020);
    // R7: banks go idle
    @(negedge clk);
    #1;
    banks_idle = 1'b1;
    #5;
    chk("R7 pulse on first idle cycle", pf_inval, 1);
    @(negedge clk);
    model_mirror = ~model_mirror;
    #6;
    chk("R11 single flip", mirror_state, model_mirror);
    chk("R7 pending cleared", swap_pending, 0);
    chk("R7 pulse ended", pf_inval, 0);

    // R10: mapping back to unswapped persists
    send(2'd0, 24'h003FEC);
    repeat (5) @(posedge clk);
    send(2'd1, 24'h083FEC);
    swap_idle();
    send(2'd0, 24'h003FEC);

    repeat (3) @(posedge clk);
    chk("scoreboard drained", sb_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule